// File: doc/BRIEF.md
# Rewindable Nine-Bit FIFO with Level Flags

This block is a first-in first-out buffer of 9-bit words whose depth is a parameter (256, 512, 1024, 2048 or 4096). Write and read strobes are sampled on the rising edge of a single clock. An accepted read places the oldest stored word on the output for one cycle and raises an output-enable alongside it. At every other time the output is disabled and driven to zero.

Three active-low flags report the fill level: empty, more-than-half, and full. A rewind strobe returns the read side to storage location zero, so a block of words can be delivered a second time, and more than once. After a rewind the occupancy is reloaded from the write position, and all flags follow from that value. Words written after a rewind are delivered after the replayed ones.

A synchronous active-high reset empties the buffer. The caller keeps both strobes low during a rewind cycle and during the cycle after it. A rewind gives the intended result only while the number of writes since reset does not exceed the depth.

Top module: `rt_fifo`

## Requirements
- R1: While reset is high and in the first cycle after it, `empty_n` = 0, `half_n` = 1, `full_n` = 1 and `rd_oe` = 0.
- R2: Accepted words leave in the order they were accepted, with all 9 bits intact. A read accepted at edge N drives `rd_data` with that word and `rd_oe` = 1 for the cycle after edge N.
- R3: A write strobe while 256-of-256 (full) is discarded. Occupancy and write position stay unchanged, and the discarded word is never delivered.
- R4: A read strobe while empty is discarded. `rd_oe` stays 0 and the read position is unchanged.
- R5: `half_n` is 0 exactly when the occupancy is at least DEPTH/2+1. It falls on the write that reaches that level and rises on the read that leaves it.
- R6: `full_n` is 0 exactly when the occupancy equals DEPTH. It rises after the first read from a full buffer.
- R7: `empty_n` is 0 exactly when the occupancy is 0. It rises after the first write into an empty buffer and falls after the read of the last word.
- R8: A write and a read in the same cycle both complete when the buffer is neither empty nor full, and the occupancy does not change. When the buffer is empty, only the write completes. When it is full, only the read completes.
- R9: A rewind strobe (`rt_stb` = 1) moves the read position to location 0 and reloads the occupancy with the number of writes since reset. Flags follow from the new occupancy. Reads then replay from the first word, and words written afterwards follow the replayed ones. Strobes in the rewind cycle are ignored.
- R10: `rd_oe` is 1 only in the cycle after an accepted read. At all other times it is 0 and `rd_data` is 0.
- R11: A rewind can be repeated any number of times, and each one replays the same sequence from location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Write request |
| wr_data | input | 9 | Word to store |
| rd_stb | input | 1 | Read request |
| rt_stb | input | 1 | Rewind request |
| rd_data | output | 9 | Word delivered by the last accepted read, else 0 |
| rd_oe | output | 1 | Output enable for `rd_data` |
| empty_n | output | 1 | Low while no word is stored |
| half_n | output | 1 | Low while more than half the depth is stored |
| full_n | output | 1 | Low while every location is in use |

## Verification
The assertions check on every cycle that each flag agrees with the internal occupancy and that the occupancy never exceeds the depth. They also check that a discarded write or read leaves its position untouched, that a paired write and read leaves the occupancy as it was, and that an enabled output follows a legal read. Whether the delivered words come out in the right order, and whether a rewind replays the right sequence (including a full-depth replay and later appended words), is shown only by the bench's scenarios. In those scenarios a behavioural queue model predicts every output.

// File: rtl/rt_fifo_pkg.sv
package rt_fifo_pkg;

    localparam int WORD_W = 9;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic empty_n;
        logic half_n;
        logic full_n;
    } flags_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_BOTH  = 2'b11
    } op_e;

    localparam flags_t FLAGS_RESET = '{empty_n: 1'b0, half_n: 1'b1, full_n: 1'b1};

    // Level flags as a function of occupancy; all active low.
    function automatic flags_t flags_of(input int unsigned occ, input int unsigned depth);
        flags_t f;
        f.empty_n = (occ != 0);
        f.half_n  = (occ <= depth / 2);
        f.full_n  = (occ != depth);
        return f;
    endfunction

endpackage

// File: rtl/rt_fifo_ptrs.sv
module rt_fifo_ptrs
    import rt_fifo_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              rt_stb,
    output logic              wr_go,
    output logic              rd_go,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  occ,
    output logic [CNT_W-1:0]  occ_nxt
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // Write position is one bit wider so that DEPTH writes are distinguishable from zero.
    logic [CNT_W-1:0]  wr_pos;
    logic [ADDR_W-1:0] rd_pos;
    op_e               op;

    assign wr_go   = wr_stb && !rt_stb && (occ != FULL_CNT);
    assign rd_go   = rd_stb && !rt_stb && (occ != '0);
    assign op      = op_e'({wr_go, rd_go});
    assign wr_addr = wr_pos[ADDR_W-1:0];
    assign rd_addr = rd_pos;

    always_comb begin
        if (rt_stb) begin
            occ_nxt = wr_pos;
        end else begin
            unique case (op)
                OP_WRITE: occ_nxt = occ + 1'b1;
                OP_READ:  occ_nxt = occ - 1'b1;
                default:  occ_nxt = occ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pos <= '0;
            rd_pos <= '0;
            occ    <= '0;
        end else begin
            occ <= occ_nxt;
            if (wr_go) wr_pos <= wr_pos + 1'b1;
            if (rt_stb)     rd_pos <= '0;
            else if (rd_go) rd_pos <= rd_pos + 1'b1;
        end
    end

    assert_occ_bound_R6: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL_CNT);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (occ == FULL_CNT && wr_stb && !rd_stb && !rt_stb) |=> $stable(wr_pos) && $stable(occ));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        (occ == '0 && rd_stb && !rt_stb) |=> $stable(rd_pos));

    assert_rewind_pos_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rt_stb) |-> (rd_pos == '0 && occ == wr_pos));

endmodule

// File: rtl/rt_fifo_mem.sv
module rt_fifo_mem
    import rt_fifo_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rdata,
    output logic              roe
);

    word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            roe   <= 1'b0;
        end else if (re) begin
            rdata <= store[raddr];
            roe   <= 1'b1;
        end else begin
            rdata <= '0;
            roe   <= 1'b0;
        end
    end

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !roe |-> (rdata == '0));

endmodule

// File: rtl/rt_fifo_flags.sv
module rt_fifo_flags
    import rt_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] occ_nxt,
    output flags_t           flags
);

    always_ff @(posedge clk) begin
        if (rst) flags <= FLAGS_RESET;
        else     flags <= flags_of(32'(occ_nxt), DEPTH);
    end

    assert_flag_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !flags.full_n |-> (!flags.half_n && flags.empty_n));

endmodule

// File: rtl/rt_fifo.sv
module rt_fifo
    import rt_fifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_stb,
    input  logic [8:0] wr_data,
    input  logic       rd_stb,
    input  logic       rt_stb,
    output logic [8:0] rd_data,
    output logic       rd_oe,
    output logic       empty_n,
    output logic       half_n,
    output logic       full_n
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

    logic              wr_go, rd_go;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [CNT_W-1:0]  occ, occ_nxt;
    flags_t            flags;
    word_t             rdata;

    rt_fifo_ptrs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ptrs (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .rt_stb  (rt_stb),
        .wr_go   (wr_go),
        .rd_go   (rd_go),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .occ     (occ),
        .occ_nxt (occ_nxt)
    );

    rt_fifo_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_go),
        .waddr (wr_addr),
        .wdata (word_t'(wr_data)),
        .re    (rd_go),
        .raddr (rd_addr),
        .rdata (rdata),
        .roe   (rd_oe)
    );

    rt_fifo_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_flags (
        .clk     (clk),
        .rst     (rst),
        .occ_nxt (occ_nxt),
        .flags   (flags)
    );

    assign rd_data = rdata;
    assign empty_n = flags.empty_n;
    assign half_n  = flags.half_n;
    assign full_n  = flags.full_n;

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (!empty_n && half_n && full_n && !rd_oe));

    assert_empty_level_R7: assert property (@(posedge clk) disable iff (rst)
        empty_n == (occ != '0));

    assert_half_level_R5: assert property (@(posedge clk) disable iff (rst)
        half_n == (occ <= HALF_CNT));

    assert_full_level_R6: assert property (@(posedge clk) disable iff (rst)
        full_n == (occ != FULL_CNT));

    assert_oe_cause_R10: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> $past(rd_stb && empty_n && !rt_stb));

    assert_pair_balance_R8: assert property (@(posedge clk) disable iff (rst)
        $past(wr_stb && rd_stb && !rt_stb && empty_n && full_n) |-> (occ == $past(occ)));

endmodule

// File: tb/test_rt_fifo.sv
`timescale 1ns/1ps
module test_rt_fifo;
    import rt_fifo_pkg::*;

    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic       rd_stb = 1'b0;
    logic       rt_stb = 1'b0;
    logic [8:0] rd_data;
    logic       rd_oe, empty_n, half_n, full_n;

    always #2 clk = ~clk;

    rt_fifo #(.DEPTH(DEPTH)) i_rt_fifo (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .rt_stb(rt_stb), .rd_data(rd_data), .rd_oe(rd_oe),
        .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
    );

    // Behavioural reference: every word written since reset, plus read index.
    word_t hist[$];
    int    wr_cnt, rd_idx, pat;
    bit    exp_oe;
    int    exp_dat;
    int    n_chk = 0, n_bad = 0;
    bit    done = 0;

    function automatic int occ_m();
        return wr_cnt - rd_idx;
    endfunction

    task automatic chk(input bit ok, input string req, input string scen, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, scen, $time, act, exp);
        end
    endtask

    task automatic compare(input string scen);
        int o;
        o = occ_m();
        chk(rd_oe === exp_oe, "R10 rd_oe", scen, int'(rd_oe), int'(exp_oe));
        if (exp_oe) chk(int'(rd_data) == exp_dat, "R2 rd_data", scen, int'(rd_data), exp_dat);
        else        chk(rd_data === 9'd0, "R10 idle data", scen, int'(rd_data), 0);
        chk(empty_n === (o != 0), "R7 empty_n", scen, int'(empty_n), int'(o != 0));
        chk(half_n === (o <= DEPTH / 2), "R5 half_n", scen, int'(half_n), int'(o <= DEPTH / 2));
        chk(full_n === (o != DEPTH), "R6 full_n", scen, int'(full_n), int'(o != DEPTH));
    endtask

    task automatic step(input bit w, input bit r, input bit t, input string scen);
        word_t d;
        int    o;
        d = word_t'(pat * 53 + 17);
        pat++;
        wr_stb = w; rd_stb = r; rt_stb = t; wr_data = d;
        @(posedge clk);
        exp_oe = 0;
        if (t) begin
            rd_idx = 0;
        end else begin
            o = occ_m();
            if (r && o > 0) begin
                exp_oe  = 1;
                exp_dat = int'(hist[rd_idx]);
                rd_idx++;
            end
            if (w && o < DEPTH) begin
                hist.push_back(d);
                wr_cnt++;
            end
        end
        @(negedge clk);
        wr_stb = 0; rd_stb = 0; rt_stb = 0;
        compare(scen);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; wr_stb = 0; rd_stb = 0; rt_stb = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        hist.delete();
        wr_cnt = 0; rd_idx = 0; exp_oe = 0;
        chk(!empty_n && half_n && full_n && !rd_oe, "R1 reset flags", "R1",
            int'({empty_n, half_n, full_n, rd_oe}), 4'b0110);
    endtask

    initial begin : main
        pat = 1;
        do_reset();

        // R2 / R7: short ordered transfer
        for (int i = 0; i < 5; i++) step(1, 0, 0, "R2 write");
        for (int i = 0; i < 5; i++) step(0, 1, 0, "R2 read");

        // R4: reads on empty
        for (int i = 0; i < 3; i++) step(0, 1, 0, "R4 empty read");

        // R5 / R6 / R3: fill past capacity, then drain
        for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 0, "R3 fill");
        step(0, 1, 0, "R6 release");
        for (int i = 0; i < DEPTH - 1; i++) step(0, 1, 0, "R5 drain");
        step(0, 1, 0, "R4 drained read");

        // R8: paired strobes at empty, mid and full
        do_reset();
        step(1, 1, 0, "R8 empty pair");
        for (int i = 0; i < 3; i++) step(1, 0, 0, "R8 prime");
        for (int i = 0; i < 4; i++) step(1, 1, 0, "R8 mid pair");
        while (occ_m() < DEPTH) step(1, 0, 0, "R8 fill");
        step(1, 1, 0, "R8 full pair");
        step(1, 1, 0, "R8 near-full pair");

        // R9 / R11: rewind with partial read, appended words, repeat
        do_reset();
        for (int i = 0; i < 10; i++) step(1, 0, 0, "R9 write");
        for (int i = 0; i < 6; i++) step(0, 1, 0, "R9 read");
        step(0, 0, 1, "R9 rewind");
        step(0, 0, 0, "R9 settle");
        for (int i = 0; i < 10; i++) step(0, 1, 0, "R9 replay");
        for (int i = 0; i < 3; i++) step(1, 0, 0, "R9 append");
        for (int i = 0; i < 3; i++) step(0, 1, 0, "R9 append read");
        step(0, 0, 1, "R11 rewind again");
        step(0, 0, 0, "R11 settle");
        for (int i = 0; i < 14; i++) step(0, 1, 0, "R11 replay");

        // R9: full-depth rewind must restore a full buffer
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, "R9 deep write");
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, "R9 deep read");
        step(0, 0, 1, "R9 deep rewind");
        step(0, 0, 0, "R9 deep settle");
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, "R9 deep replay");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired at t=%0t actual=running expected=finished", $time);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule